// File: doc/BRIEF.md
# SMBus Configuration Register File

This block is a two-wire bus target that holds the configuration bytes of a clock generator. It decodes START and STOP conditions, matches its 7-bit target address, acknowledges bytes by pulling the data line low, and serves four transaction types: single-byte write, single-byte read, block write and block read. The register contents are presented in parallel on `cfg_bytes`, so the rest of the chip sees every setting at all times. A one-cycle strobe marks each register that has just been written.

Every register comes out of reset holding a default computed from a fixed formula, so the clock generator runs with no programming. The command byte that follows the address selects byte or block mode and carries the starting register offset. Block transfers walk upward through the bank one offset at a time, and the host may end them after any whole byte. A write takes effect on the rising clock edge of the ACK bit that follows the data byte. The two low address bits can come from strap pins, which lets up to four targets share one bus.

The bus inputs are sampled by the system clock `clk`, so SCL must be much slower than `clk`. The block never stretches the clock and never drives the data line high.

Top module: `smbcfg_regfile`

## Requirements
- R1: After reset, register byte i holds (29*i + 17) mod 256 for every i below NUM_REGS, and SDA is released (`sda_drive_low` = 0).
- R2: The target address is {5'b11010, addr_strap[1:0]}. An address byte whose top 7 bits match it is ACKed. A mismatching address is NACKed, and the data bytes after it change no register.
- R3: In the first byte after a write address, bit 7 = 1 selects block mode and bit 7 = 0 selects byte mode. Bits 6:0 give the starting offset.
- R4: A byte write stores the data byte at the offset from the command, and every byte the host sends in a matched transaction is ACKed.
- R5: A data byte is committed on the rising SCL edge of its ACK bit. The register is unchanged during the ACK low phase and updated within 4 `clk` cycles after SCL rises. Exactly one bit of `cfg_wr_strobe` pulses for that write.
- R6: In a block write, the first byte after the command is a count, which is ACKed and not stored. The data bytes that follow go to consecutive rising offsets starting at the command offset.
- R7: A block write ended by STOP after any whole byte keeps every byte already committed and leaves the higher offsets untouched.
- R8: A byte read, made with the command, a repeated START and a read address, returns the register at the command offset, most significant bit first.
- R9: A block read first returns a count equal to NUM_REGS minus the offset (0 when the offset is at or beyond NUM_REGS). It then returns registers from the offset upward.
- R10: A write to an offset at or beyond NUM_REGS is ACKed and discarded, with no strobe. A read from such an offset returns 0x00.
- R11: SDA is only ever pulled low and changes only while SCL is low. After the host NACKs a read byte, SDA stays released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset; reloads the defaults |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 2 | Low two bits of the target address |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |
| cfg_bytes | output | NUM_REGS*8 | All registers; byte i at bits [8*i+7:8*i] |
| cfg_wr_strobe | output | NUM_REGS | One-cycle pulse on the bit of each register written |

## Verification
Each bus edge passes through a two-stage synchronizer and an edge register before the protocol engine sees it. The write strobe therefore appears about three `clk` cycles after SCL rises in the ACK bit, and the register updates one cycle after that. The bench checks the old value while SCL is still low and the new value 4 cycles after the rise. Responses on SDA (ACK and read data) change about three cycles after SCL falls. The bench holds each SCL phase for 8 cycles and samples the line in the middle of the high phase, well after any change the target makes.

// File: rtl/smbcfg_pkg.sv
// Package: shared types and default-image function for the SMBus register file.
// Assumes the register bank never exceeds 128 bytes (7-bit offset field).
package smbcfg_pkg;

    // Protocol phases of the target engine.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK,
        PH_DROP
    } phase_t;

    // Meaning of the byte whose ACK is in progress.
    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_CNT,
        K_DATA
    } rxkind_t;

    // Default contents of register idx after reset.
    function automatic logic [7:0] dflt_byte(int unsigned idx);
        return 8'((idx * 29 + 17) % 256);
    endfunction

endpackage

// File: rtl/smbcfg_line_sync.sv
// Module: synchronizes SCL/SDA into the clk domain and flags bus events.
// Assumes SCL and SDA hold each level for several clk cycles.
module smbcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // Synchronizer chains; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Event decode: clock edges and data edges while the clock is high.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/smbcfg_reg_bank.sv
// Module: configuration registers with reset defaults, one write port,
// one combinational read port and per-register write strobes.
// Assumes wr_addr/rd_addr beyond NUM_REGS select nothing (read gives 0).
module smbcfg_reg_bank
    import smbcfg_pkg::*;
#(
    parameter int NUM_REGS = 26,
    parameter int AW       = 8,
    parameter int DW       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    output logic [NUM_REGS*DW-1:0] cfg_flat,
    output logic [NUM_REGS-1:0]    wr_strobe
);

    logic [DW-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Write decode for this register.
        assign wr_strobe[g] = wr_en && (wr_addr == AW'(g));

        // Storage: default on reset, new data on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= DW'(dflt_byte(g));
            else if (wr_strobe[g])
                regs[g] <= wr_data;
        end

        assign cfg_flat[g*DW +: DW] = regs[g];
    end

    // Read mux; out-of-range offsets read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == AW'(i))
                rd_data = regs[i];
    end

endmodule

// File: rtl/smbcfg_fsm.sv
// Module: bus target protocol engine. Receives address, command and data
// bytes, drives ACK and read data, and issues register writes on the
// rising SCL edge of each data ACK.
// Assumes events come from smbcfg_line_sync and NUM_REGS <= 128.
module smbcfg_fsm
    import smbcfg_pkg::*;
#(
    parameter int NUM_REGS = 26,
    parameter int AW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_s,
    input  logic [6:0]    dev_addr,
    input  logic [7:0]    rd_data,
    output logic          sda_low,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_addr
);

    localparam logic [AW-1:0] PTR_MAX  = '1;
    localparam logic [AW-1:0] BANK_TOP = AW'(NUM_REGS);

    phase_t        phase;
    rxkind_t       kind;
    logic [3:0]    bcnt;
    logic [7:0]    shreg;
    logic [AW-1:0] ptr;
    logic          is_read;
    logic          cmd_done;
    logic          cnt_pend;
    logic          host_nack;
    logic [7:0]    cnt_val;
    logic [7:0]    tx_next;
    logic [AW-1:0] ptr_inc;

    // Block-read count, next byte to send and saturating pointer step.
    always_comb begin
        cnt_val = (ptr < BANK_TOP) ? 8'(BANK_TOP - ptr) : 8'h00;
        tx_next = cnt_pend ? cnt_val : rd_data;
        ptr_inc = (ptr == PTR_MAX) ? ptr : ptr + 1'b1;
    end

    // Register write request: data byte ACK, rising SCL.
    assign wr_en   = (phase == PH_RX_ACK) && scl_rise && (kind == K_DATA)
                     && !start_det && !stop_det;
    assign wr_addr = ptr;
    assign wr_data = shreg;
    assign rd_addr = ptr;

    // Protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            kind      <= K_ADDR;
            bcnt      <= '0;
            shreg     <= '0;
            ptr       <= '0;
            is_read   <= 1'b0;
            cmd_done  <= 1'b0;
            cnt_pend  <= 1'b0;
            host_nack <= 1'b0;
            sda_low   <= 1'b0;
        end else if (start_det) begin
            phase   <= PH_ADDR;
            bcnt    <= '0;
            sda_low <= 1'b0;
        end else if (stop_det) begin
            phase    <= PH_IDLE;
            sda_low  <= 1'b0;
            cmd_done <= 1'b0;
            cnt_pend <= 1'b0;
        end else begin
            unique case (phase)
                PH_ADDR, PH_RX: begin
                    if (scl_rise && bcnt != 4'd8) begin
                        shreg <= {shreg[6:0], sda_s};
                        bcnt  <= bcnt + 1'b1;
                    end else if (scl_fall && bcnt == 4'd8) begin
                        if (phase == PH_ADDR) begin
                            if (shreg[7:1] == dev_addr) begin
                                is_read <= shreg[0];
                                kind    <= K_ADDR;
                                sda_low <= 1'b1;
                                phase   <= PH_RX_ACK;
                            end else begin
                                phase <= PH_DROP;
                            end
                        end else begin
                            if (!cmd_done) begin
                                ptr      <= AW'(shreg[6:0]);
                                cnt_pend <= shreg[7];
                                cmd_done <= 1'b1;
                                kind     <= K_CMD;
                            end else if (cnt_pend) begin
                                cnt_pend <= 1'b0;
                                kind     <= K_CNT;
                            end else begin
                                kind <= K_DATA;
                            end
                            sda_low <= 1'b1;
                            phase   <= PH_RX_ACK;
                        end
                    end
                end
                PH_RX_ACK: begin
                    if (scl_rise && kind == K_DATA)
                        ptr <= ptr_inc;
                    else if (scl_fall) begin
                        bcnt <= '0;
                        if (kind == K_ADDR && is_read) begin
                            shreg   <= tx_next;
                            sda_low <= ~tx_next[7];
                            phase   <= PH_TX;
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr      <= ptr_inc;
                        end else begin
                            sda_low <= 1'b0;
                            phase   <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise)
                        bcnt <= bcnt + 1'b1;
                    else if (scl_fall) begin
                        if (bcnt == 4'd8) begin
                            sda_low <= 1'b0;
                            phase   <= PH_TX_ACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_low <= ~shreg[6];
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise)
                        host_nack <= sda_s;
                    else if (scl_fall) begin
                        bcnt <= '0;
                        if (host_nack) begin
                            phase <= PH_DROP;
                        end else begin
                            shreg   <= tx_next;
                            sda_low <= ~tx_next[7];
                            phase   <= PH_TX;
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr      <= ptr_inc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smbcfg_regfile.sv
// Module: top of the SMBus configuration register file. Ties the line
// synchronizer, protocol engine and register bank together and forms
// the target address from a fixed high part and straps or fixed low bits.
// Assumes scl_in/sda_in are the resolved open-drain bus levels.
module smbcfg_regfile #(
    parameter int         NUM_REGS    = 26,
    parameter logic [4:0] ADDR_HI     = 5'b11010,
    parameter bit         USE_STRAP   = 1'b1,
    parameter logic [1:0] ADDR_LO     = 2'b00,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [1:0]            addr_strap,
    output logic                  sda_drive_low,
    output logic [NUM_REGS*8-1:0] cfg_bytes,
    output logic [NUM_REGS-1:0]   cfg_wr_strobe
);

    localparam int AW = 8;

    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic [6:0]    dev_addr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    // Address source: strap pins or fixed low bits.
    if (USE_STRAP) begin : g_strap
        assign dev_addr = {ADDR_HI, addr_strap};
    end else begin : g_fixed
        assign dev_addr = {ADDR_HI, ADDR_LO};
    end

    smbcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smbcfg_fsm #(.NUM_REGS(NUM_REGS), .AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .dev_addr  (dev_addr),
        .rd_data   (rd_data),
        .sda_low   (sda_drive_low),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr)
    );

    smbcfg_reg_bank #(.NUM_REGS(NUM_REGS), .AW(AW), .DW(8)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cfg_flat  (cfg_bytes),
        .wr_strobe (cfg_wr_strobe)
    );

endmodule

// File: rtl/smbcfg_checker.sv
// Module: protocol and commit-rule assertions for smbcfg_regfile, bound
// to every instance of it. Assumes the bus keeps SCL low for several clk.
module smbcfg_checker #(
    parameter int NUM_REGS = 26
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_in,
    input logic                  sda_drive_low,
    input logic [NUM_REGS*8-1:0] cfg_bytes,
    input logic [NUM_REGS-1:0]   cfg_wr_strobe
);

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_wr_strobe)); // R5

    AST_STROBE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (|cfg_wr_strobe) |-> scl_in); // R5

    AST_STROBE_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|cfg_wr_strobe) |-> sda_drive_low); // R4

    AST_CFG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_bytes) |-> $past(|cfg_wr_strobe)); // R5

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_in); // R11

endmodule

bind smbcfg_regfile smbcfg_checker #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/smbcfg_regfile_tb.sv
`timescale 1ns/100ps
module smbcfg_regfile_tb;

    localparam int NR = 26;
    localparam int HP = 8;
    localparam logic [7:0] AW_ = 8'hD4;   // address 0x6A, write
    localparam logic [7:0] AR_ = 8'hD5;   // address 0x6A, read
    localparam logic [7:0] AX_ = 8'hD2;   // address 0x69, write (mismatch)

    // {offset, data written, expected read-back}
    localparam logic [23:0] VEC [6] = '{
        {8'd0,   8'hA5, 8'hA5},
        {8'd7,   8'h3C, 8'h3C},
        {8'd25,  8'hFF, 8'hFF},
        {8'd12,  8'h00, 8'h00},
        {8'd45,  8'h77, 8'h00},
        {8'd127, 8'h12, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic sda_line;
    logic [NR*8-1:0] cfg_bytes;
    logic [NR-1:0]   cfg_wr_strobe;

    int n_chk = 0;
    int n_fail = 0;
    int strobe_tot = 0;
    bit done = 0;
    logic [7:0] model [NR];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    smbcfg_regfile #(.NUM_REGS(NR)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .addr_strap    (2'b10),
        .sda_drive_low (sda_drive_low),
        .cfg_bytes     (cfg_bytes),
        .cfg_wr_strobe (cfg_wr_strobe)
    );

    always @(negedge clk) strobe_tot += $countones(cfg_wr_strobe);

    function automatic logic [7:0] dflt(int i);
        return 8'((29 * i + 17) % 256);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; tick(HP);
        sda_m = 0; tick(HP);
        scl_m = 0; tick(HP);
    endtask

    task automatic bus_rstart();
        tick(2); sda_m = 1; tick(HP);
        scl_m = 1; tick(HP);
        sda_m = 0; tick(HP);
        scl_m = 0; tick(HP);
    endtask

    task automatic bus_stop();
        tick(2); sda_m = 0; tick(HP);
        scl_m = 1; tick(HP);
        sda_m = 1; tick(HP);
    endtask

    task automatic put_bit(logic b);
        tick(2); sda_m = b; tick(HP - 2);
        scl_m = 1; tick(HP);
        scl_m = 0;
    endtask

    task automatic wr_byte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        tick(2); sda_m = 1; tick(HP - 2);
        scl_m = 1; tick(HP / 2);
        ack = ~sda_line;
        tick(HP / 2);
        scl_m = 0;
    endtask

    task automatic rd_byte(logic nack, output logic [7:0] d);
        tick(2); sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(HP - 2);
            scl_m = 1; tick(HP / 2);
            d[i] = sda_line;
            tick(HP / 2);
            scl_m = 0; tick(2);
        end
        sda_m = nack; tick(HP - 2);
        scl_m = 1; tick(HP);
        scl_m = 0; tick(2);
        sda_m = 1;
    endtask

    task automatic byte_write(logic [7:0] off, logic [7:0] d);
        logic a;
        bus_start();
        wr_byte(AW_, a); chk("R2 addr ack", a, 1);
        wr_byte(off, a); chk("R4 cmd ack", a, 1);
        wr_byte(d, a);   chk("R4/R10 data ack", a, 1);
        bus_stop();
        if (off < NR) model[off] = d;
    endtask

    task automatic byte_read(logic [7:0] off, output logic [7:0] d);
        logic a;
        bus_start();
        wr_byte(AW_, a); wr_byte(off, a);
        bus_rstart();
        wr_byte(AR_, a); chk("R2 read addr ack", a, 1);
        rd_byte(1'b1, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        int s0;
        for (int i = 0; i < NR; i++) model[i] = dflt(i);
        tick(6);
        rst_n = 1;
        tick(4);

        // R1: defaults and released line
        for (int i = 0; i < NR; i++)
            chk("R1 default", cfg_bytes[i*8 +: 8], dflt(i));
        chk("R1 sda released", sda_drive_low, 0);

        // R4 R8 R10: vector table of byte write + byte read
        for (int v = 0; v < 6; v++) begin
            s0 = strobe_tot;
            byte_write(VEC[v][23:16], VEC[v][15:8]);
            byte_read(VEC[v][23:16], d);
            chk("R8/R10 byte read", d, VEC[v][7:0]);
            if (VEC[v][23:16] < NR)
                chk("R4 lane", cfg_bytes[VEC[v][23:16]*8 +: 8], VEC[v][7:0]);
            else
                chk("R10 no strobe", strobe_tot - s0, 0);
        end

        // R5: commit happens at the rising SCL of the ACK bit
        s0 = strobe_tot;
        bus_start();
        wr_byte(AW_, a); wr_byte(8'd9, a);
        for (int i = 7; i >= 0; i--) put_bit(8'h5A >> i);
        tick(2); sda_m = 1; tick(HP - 2);
        chk("R5 before ack rise", cfg_bytes[9*8 +: 8], model[9]);
        chk("R5 ack driven", sda_drive_low, 1);
        scl_m = 1; tick(4);
        chk("R5 after ack rise", cfg_bytes[9*8 +: 8], 8'h5A);
        chk("R5 one strobe", strobe_tot - s0, 1);
        tick(HP - 4); scl_m = 0;
        bus_stop();
        model[9] = 8'h5A;

        // R3 R6: block write at offset 3, count byte then three data bytes
        bus_start();
        wr_byte(AW_, a); wr_byte(8'h83, a); chk("R3 block cmd ack", a, 1);
        wr_byte(8'd3, a);  chk("R6 count ack", a, 1);
        wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
        bus_stop();
        model[3] = 8'h11; model[4] = 8'h22; model[5] = 8'h33;
        for (int i = 3; i <= 6; i++)
            chk("R6 block write", cfg_bytes[i*8 +: 8], model[i]);

        // R7: block write cut short after two data bytes
        bus_start();
        wr_byte(AW_, a); wr_byte(8'h8E, a); wr_byte(8'd5, a);
        wr_byte(8'hC1, a); wr_byte(8'hC2, a);
        bus_stop();
        model[14] = 8'hC1; model[15] = 8'hC2;
        for (int i = 14; i <= 16; i++)
            chk("R7 early stop", cfg_bytes[i*8 +: 8], model[i]);

        // R9 R10 R11: block read from 22, one extra byte past the bank
        bus_start();
        wr_byte(AW_, a); wr_byte(8'h96, a);
        bus_rstart();
        wr_byte(AR_, a);
        rd_byte(1'b0, d); chk("R9 count", d, 8'd4);
        for (int i = 22; i < NR; i++) begin
            rd_byte(1'b0, d); chk("R9 block data", d, model[i]);
        end
        rd_byte(1'b1, d); chk("R10 past bank", d, 8'h00);
        put_bit(1'b1);
        chk("R11 released after nack", sda_drive_low, 0);
        bus_stop();

        // R9: block read starting beyond the bank gives count 0
        bus_start();
        wr_byte(AW_, a); wr_byte(8'hA8, a);
        bus_rstart();
        wr_byte(AR_, a);
        rd_byte(1'b1, d); chk("R9 zero count", d, 8'h00);
        bus_stop();

        // R2: mismatching address is NACKed and writes nothing
        s0 = strobe_tot;
        bus_start();
        wr_byte(AX_, a); chk("R2 mismatch nack", a, 0);
        wr_byte(8'd1, a); wr_byte(8'hEE, a);
        bus_stop();
        chk("R2 reg untouched", cfg_bytes[1*8 +: 8], model[1]);
        chk("R2 no strobe", strobe_tot - s0, 0);

        // R1: reset restores defaults
        tick(2); rst_n = 0; tick(3); rst_n = 1; tick(2);
        chk("R1 reload 0", cfg_bytes[0 +: 8], dflt(0));
        chk("R1 reload 9", cfg_bytes[9*8 +: 8], dflt(9));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule